// File: doc/BRIEF.md
# Segment Descriptor Lookup Unit

This unit services a write of a 16-bit selector into one of the segment registers while protected operation is on. The selector carries a 13-bit index, a table-choice bit and a 2-bit requester privilege field. The table-choice bit picks either the global table or the local table. The index, scaled by eight, is checked against that table's limit. The unit then adds it to the table base to form the address of an 8-byte descriptor, reads the descriptor as two 32-bit words over a request/acknowledge memory port, and stores the decoded base, limit, access byte and flag nibble in a per-register shadow cache.

The global table register is written by software as three 16-bit words. The local table register is only filled by a lookup. That lookup reads a descriptor from the global table and copies its base and limit into the local table register. Later lookups with the table-choice bit set use the new values. Privilege rules and descriptor type rules are not handled here. The unit flags a null global selector, an offset past the table limit, and a local-table load that names the local table.

Top module: `seg_desc_lookup`

## Requirements
- R1: Selector bits 15:3 form the index, bit 2 picks the table (0 global, 1 local), and bits 1:0 have no effect on addressing. The first read goes to the chosen table base plus `{sel[15:3],3'b000}`.
- R2: A lookup is made only when offset + 7 <= the chosen table limit. Otherwise, one cycle after the write, `fault_o` pulses with `fault_code` = 2, no memory request is made and the cache is left unchanged.
- R3: A selector with bit 2 = 0 and index 0 faults with `fault_code` = 1 and makes no memory request. Local-table index 0 is fetched like any other entry.
- R4: A lookup makes exactly two reads, at A and then A+4. `mem_req` stays high with a stable `mem_addr` until `mem_ack` is sampled high.
- R5: With low word L and high word H, the cache holds base = {H[31:24],H[7:0],L[31:16]}, limit = {H[19:16],L[15:0]}, access = H[15:8] and flags = H[23:20]. After the second acknowledge, the entry at `sel_tgt` reads back valid with those values.
- R6: `gdtr_wr` with `gdtr_idx` 0 loads the global limit, 1 loads base bits 15:0 and 2 loads base bits BASE_W-1:16. Index 3 is ignored.
- R7: A write with `sel_ldtr` = 1 looks up the global table and loads the decoded base and limit into the local table register, visible on `ldt_base_o`/`ldt_lim_o`. If bit 2 of that selector is 1, the write faults with `fault_code` = 3 instead.
- R8: `busy` is high from the cycle after an accepted write until the second acknowledge edge, and `done_o` pulses in the cycle after that edge. A selector write while `busy` is high is ignored.
- R9: After reset, `busy`, `mem_req`, `done_o` and `fault_o` are low, `fault_code` is 0, every cache entry reads invalid and the local table register is zero.
- R10: A fault leaves every cache entry and the local table register unchanged, and `done_o` and `fault_o` never rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Selector write strobe |
| sel_val | input | 16 | Selector value |
| sel_tgt | input | IDX_W | Target segment register index |
| sel_ldtr | input | 1 | Write targets the local table register |
| gdtr_wr | input | 1 | Global table register word write |
| gdtr_idx | input | 2 | Word select: 0 limit, 1 base low, 2 base high |
| gdtr_data | input | 16 | Word value |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | BASE_W | Read byte address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Lookup in progress |
| done_o | output | 1 | One-cycle pulse after a completed lookup |
| fault_o | output | 1 | One-cycle fault pulse |
| fault_code | output | 2 | Last fault: 1 null, 2 limit, 3 table |
| rd_idx | input | IDX_W | Cache read index |
| rd_valid | output | 1 | Entry holds a descriptor |
| rd_base | output | 32 | Cached base |
| rd_limit | output | 20 | Cached limit |
| rd_acc | output | 8 | Cached access byte |
| rd_flags | output | 4 | Cached flag nibble |
| ldt_base_o | output | BASE_W | Local table base |
| ldt_lim_o | output | 20 | Local table limit |

## Verification
A wrong table choice or offset appears on `mem_addr` in the first cycle after the write. A corrupted local table register appears on `ldt_base_o` right away, and on the next local-table address. A sequencer stuck in a read state keeps `busy` high and never produces `done_o`, so a missing second read is caught within a few cycles. A wrong field mapping or a write to the wrong entry, including one caused by an ignored write that was wrongly taken, shows up on the cache read port as soon as the lookup ends.

// File: rtl/seg_lookup_pkg.sv
package seg_lookup_pkg;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_NULL  = 2'd1,
    FLT_LIMIT = 2'd2,
    FLT_TABLE = 2'd3
  } flt_e;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic [7:0]  acc;
    logic [3:0]  flg;
  } desc_t;

  // byte offset of the entry: index scaled by eight
  function automatic logic [15:0] sel_offset(input logic [15:0] s);
    return {s[15:3], 3'b000};
  endfunction

  // whole 8-byte entry must lie at or below the limit
  function automatic logic entry_fits(input logic [15:0] off, input logic [19:0] lim);
    logic [20:0] last;
    last = {5'd0, off} + 21'd7;
    return last <= {1'b0, lim};
  endfunction

  function automatic desc_t unpack_desc(input logic [31:0] lo, input logic [31:0] hi);
    desc_t d;
    d.base  = {hi[31:24], hi[7:0], lo[31:16]};
    d.limit = {hi[19:16], lo[15:0]};
    d.acc   = hi[15:8];
    d.flg   = hi[23:20];
    return d;
  endfunction

endpackage

// File: rtl/seg_table_regs.sv
module seg_table_regs
  import seg_lookup_pkg::*;
#(
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gw_en,
  input  logic [1:0]        gw_idx,
  input  logic [15:0]       gw_data,
  input  logic              lw_en,
  input  desc_t             lw_desc,
  output logic [BASE_W-1:0] gdt_base,
  output logic [15:0]       gdt_lim,
  output logic [BASE_W-1:0] ldt_base,
  output logic [19:0]       ldt_lim
);
  localparam int HI_W = BASE_W - 16;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gdt_base <= '0;
      gdt_lim  <= '0;
    end else if (gw_en) begin
      case (gw_idx)
        2'd0:    gdt_lim <= gw_data;
        2'd1:    gdt_base[15:0] <= gw_data;
        2'd2:    gdt_base[BASE_W-1:16] <= gw_data[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldt_base <= '0;
      ldt_lim  <= '0;
    end else if (lw_en) begin
      ldt_base <= lw_desc.base[BASE_W-1:0];
      ldt_lim  <= lw_desc.limit;
    end
  end

endmodule

// File: rtl/seg_sel_check.sv
module seg_sel_check
  import seg_lookup_pkg::*;
#(
  parameter int BASE_W = 32
) (
  input  logic [15:0]       sel,
  input  logic              for_ldtr,
  input  logic [BASE_W-1:0] gdt_base,
  input  logic [15:0]       gdt_lim,
  input  logic [BASE_W-1:0] ldt_base,
  input  logic [19:0]       ldt_lim,
  output logic [BASE_W-1:0] addr,
  output logic              is_null,
  output logic              ok,
  output logic [1:0]        code
);
  logic              ti;
  logic              use_ldt;
  logic [15:0]       off;
  logic [BASE_W-1:0] base_sel;
  logic [19:0]       lim_sel;
  logic              tbl_bad;
  logic              lim_bad;

  always_comb begin
    ti       = sel[2];
    off      = sel_offset(sel);
    use_ldt  = ti && !for_ldtr;
    base_sel = use_ldt ? ldt_base : gdt_base;
    lim_sel  = use_ldt ? ldt_lim : {4'd0, gdt_lim};
    addr     = base_sel + BASE_W'(off);
    is_null  = !ti && (sel[15:3] == 13'd0);
    tbl_bad  = for_ldtr && ti;
    lim_bad  = !entry_fits(off, lim_sel);
    if (tbl_bad)      code = FLT_TABLE;
    else if (is_null) code = FLT_NULL;
    else if (lim_bad) code = FLT_LIMIT;
    else              code = FLT_NONE;
    ok = (code == FLT_NONE);
  end

endmodule

// File: rtl/seg_fetch_ctrl.sv
module seg_fetch_ctrl #(
  parameter int BASE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BASE_W-1:0] start_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              mem_req,
  output logic [BASE_W-1:0] mem_addr,
  output logic              busy,
  output logic              fin,
  output logic [31:0]       word_lo
);
  typedef enum logic [1:0] {S_IDLE, S_LO, S_HI} st_e;

  st_e               st;
  logic [BASE_W-1:0] addr_q;
  logic [31:0]       lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_LO;
          addr_q <= start_addr;
        end
        S_LO: if (mem_ack) begin
          lo_q   <= mem_rdata;
          addr_q <= addr_q + BASE_W'(4);
          st     <= S_HI;
        end
        S_HI: if (mem_ack) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req  = (st != S_IDLE);
  assign mem_addr = addr_q;
  assign busy     = (st != S_IDLE);
  assign fin      = (st == S_HI) && mem_ack;
  assign word_lo  = lo_q;

endmodule

// File: rtl/seg_shadow_bank.sv
module seg_shadow_bank
  import seg_lookup_pkg::*;
#(
  parameter int NSEG = 4,
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  desc_t            wr_desc,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output desc_t            rd_desc
);
  logic [NSEG-1:0] vld;
  desc_t           ent [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic  v_q;
    desc_t d_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        v_q <= 1'b1;
        d_q <= wr_desc;
      end
    end
    assign vld[g] = v_q;
    assign ent[g] = d_q;
  end

  always_comb begin
    rd_valid = 1'b0;
    rd_desc  = '0;
    for (int i = 0; i < NSEG; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_valid = vld[i];
        rd_desc  = ent[i];
      end
    end
  end

endmodule

// File: rtl/seg_desc_lookup.sv
module seg_desc_lookup
  import seg_lookup_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int NSEG = 4,
  localparam int IDX_W = (NSEG > 1) ? $clog2(NSEG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic [15:0]       sel_val,
  input  logic [IDX_W-1:0]  sel_tgt,
  input  logic              sel_ldtr,
  input  logic              gdtr_wr,
  input  logic [1:0]        gdtr_idx,
  input  logic [15:0]       gdtr_data,
  output logic              mem_req,
  output logic [BASE_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              busy,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_code,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [31:0]       rd_base,
  output logic [19:0]       rd_limit,
  output logic [7:0]        rd_acc,
  output logic [3:0]        rd_flags,
  output logic [BASE_W-1:0] ldt_base_o,
  output logic [19:0]       ldt_lim_o
);
  // named events, also used by the bound checker
  logic              acc_go;
  logic              chk_ok;
  logic              chk_null;
  logic [1:0]        chk_code;
  logic [BASE_W-1:0] chk_addr;
  logic              fin;
  logic              commit_seg;
  logic              commit_ldt;

  logic [BASE_W-1:0] gdt_base;
  logic [15:0]       gdt_lim;
  logic [31:0]       word_lo;
  desc_t             new_desc;
  desc_t             rd_desc;
  logic [IDX_W-1:0]  tgt_q;
  logic              ldtr_q;

  assign acc_go     = sel_wr && !busy;
  assign new_desc   = unpack_desc(word_lo, mem_rdata);
  assign commit_seg = fin && !ldtr_q;
  assign commit_ldt = fin && ldtr_q;

  seg_table_regs #(.BASE_W(BASE_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .gw_en    (gdtr_wr),
    .gw_idx   (gdtr_idx),
    .gw_data  (gdtr_data),
    .lw_en    (commit_ldt),
    .lw_desc  (new_desc),
    .gdt_base (gdt_base),
    .gdt_lim  (gdt_lim),
    .ldt_base (ldt_base_o),
    .ldt_lim  (ldt_lim_o)
  );

  seg_sel_check #(.BASE_W(BASE_W)) u_chk_sel (
    .sel      (sel_val),
    .for_ldtr (sel_ldtr),
    .gdt_base (gdt_base),
    .gdt_lim  (gdt_lim),
    .ldt_base (ldt_base_o),
    .ldt_lim  (ldt_lim_o),
    .addr     (chk_addr),
    .is_null  (chk_null),
    .ok       (chk_ok),
    .code     (chk_code)
  );

  seg_fetch_ctrl #(.BASE_W(BASE_W)) u_fetch (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (acc_go && chk_ok),
    .start_addr (chk_addr),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .busy       (busy),
    .fin        (fin),
    .word_lo    (word_lo)
  );

  seg_shadow_bank #(.NSEG(NSEG)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (commit_seg),
    .wr_idx   (tgt_q),
    .wr_desc  (new_desc),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_desc  (rd_desc)
  );

  assign rd_base  = rd_desc.base;
  assign rd_limit = rd_desc.limit;
  assign rd_acc   = rd_desc.acc;
  assign rd_flags = rd_desc.flg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q      <= '0;
      ldtr_q     <= 1'b0;
      done_o     <= 1'b0;
      fault_o    <= 1'b0;
      fault_code <= FLT_NONE;
    end else begin
      done_o  <= fin;
      fault_o <= acc_go && !chk_ok;
      if (acc_go) begin
        tgt_q  <= sel_tgt;
        ldtr_q <= sel_ldtr;
        if (!chk_ok) fault_code <= chk_code;
      end
    end
  end

endmodule

// File: rtl/seg_lookup_chk.sv
module seg_lookup_chk #(
  parameter int BASE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_wr,
  input logic              busy,
  input logic              acc_go,
  input logic              chk_ok,
  input logic              chk_null,
  input logic              mem_req,
  input logic              mem_ack,
  input logic [BASE_W-1:0] mem_addr,
  input logic              fin,
  input logic              done_o,
  input logic              fault_o,
  input logic [1:0]        fault_code
);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_second_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !fin |=> mem_req && (mem_addr == $past(mem_addr) + BASE_W'(4)));

  p_fault_no_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go && !chk_ok |=> fault_o && !busy && !mem_req);

  p_null_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_go && chk_null |=> fault_o && (fault_code == 2'd1));

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(busy) && !busy);

  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && sel_wr && !fin |=> busy && !fault_o);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fault_o));

endmodule

bind seg_desc_lookup seg_lookup_chk #(.BASE_W(BASE_W)) u_lookup_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_wr     (sel_wr),
  .busy       (busy),
  .acc_go     (acc_go),
  .chk_ok     (chk_ok),
  .chk_null   (chk_null),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_addr   (mem_addr),
  .fin        (fin),
  .done_o     (done_o),
  .fault_o    (fault_o),
  .fault_code (fault_code)
);

// File: tb/sim_seg_desc_lookup.sv
`timescale 1ns/1ps
module sim_seg_desc_lookup;
  localparam int BW = 32;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr = 1'b0;
  logic [15:0] sel_val = '0;
  logic [1:0]  sel_tgt = '0;
  logic        sel_ldtr = 1'b0;
  logic        gdtr_wr = 1'b0;
  logic [1:0]  gdtr_idx = '0;
  logic [15:0] gdtr_data = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        busy, done_o, fault_o;
  logic [1:0]  fault_code;
  logic [1:0]  rd_idx = '0;
  logic        rd_valid;
  logic [31:0] rd_base;
  logic [19:0] rd_limit;
  logic [7:0]  rd_acc;
  logic [3:0]  rd_flags;
  logic [31:0] ldt_base_o;
  logic [19:0] ldt_lim_o;

  int nchk = 0;
  int nbad = 0;

  logic        ev [NS];
  logic [31:0] eb [NS];
  logic [19:0] el [NS];
  logic [7:0]  ea [NS];
  logic [3:0]  ef [NS];
  logic [31:0] e_ldt_b;
  logic [19:0] e_ldt_l;

  localparam logic [31:0] GBASE = 32'h0001_1000;
  localparam logic [31:0] LBASE = 32'h0020_0000;

  seg_desc_lookup #(.BASE_W(BW), .NSEG(NS)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_val(sel_val), .sel_tgt(sel_tgt),
    .sel_ldtr(sel_ldtr), .gdtr_wr(gdtr_wr), .gdtr_idx(gdtr_idx), .gdtr_data(gdtr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .busy(busy), .done_o(done_o), .fault_o(fault_o), .fault_code(fault_code),
    .rd_idx(rd_idx), .rd_valid(rd_valid), .rd_base(rd_base), .rd_limit(rd_limit),
    .rd_acc(rd_acc), .rd_flags(rd_flags), .ldt_base_o(ldt_base_o), .ldt_lim_o(ldt_lim_o)
  );

  always #4 clk = ~clk;

  // memory image: arithmetic fill, one local-table descriptor at global index 3
  function automatic logic [31:0] memw(input logic [31:0] a);
    if (a == GBASE + 32'h18) return 32'h0000_0027;
    if (a == GBASE + 32'h1C) return 32'h0000_8220;
    return (a * 32'h9E37_79B1) ^ 32'h1357_9BDF;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic check_shadow(input string req);
    for (int i = 0; i < NS; i++) begin
      @(negedge clk);
      rd_idx = i[1:0];
      #1;
      chk(rd_valid == ev[i], req, "entry valid", {31'd0, rd_valid}, {31'd0, ev[i]});
      if (ev[i]) begin
        chk(rd_base == eb[i], req, "entry base", rd_base, eb[i]);
        chk(rd_limit == el[i], req, "entry limit", {12'd0, rd_limit}, {12'd0, el[i]});
        chk(rd_acc == ea[i], req, "entry access", {24'd0, rd_acc}, {24'd0, ea[i]});
        chk(rd_flags == ef[i], req, "entry flags", {28'd0, rd_flags}, {28'd0, ef[i]});
      end
    end
    chk(ldt_base_o == e_ldt_b, req, "ldt base", ldt_base_o, e_ldt_b);
    chk(ldt_lim_o == e_ldt_l, req, "ldt limit", {12'd0, ldt_lim_o}, {12'd0, e_ldt_l});
  endtask

  task automatic gdtr_put(input logic [1:0] idx, input logic [15:0] d);
    @(negedge clk);
    gdtr_wr = 1'b1; gdtr_idx = idx; gdtr_data = d;
    @(negedge clk);
    gdtr_wr = 1'b0;
  endtask

  task automatic run_lookup(input logic [15:0] s, input logic to_ldtr, input logic [1:0] tgt,
                            input logic inject, output logic flt, output logic [1:0] code,
                            output logic [31:0] a0, output logic [31:0] a1, output int nrd);
    int waitc;
    int guard;
    flt = 1'b0; code = 2'd0; a0 = '0; a1 = '0; nrd = 0;
    @(negedge clk);
    sel_wr = 1'b1; sel_val = s; sel_ldtr = to_ldtr; sel_tgt = tgt;
    @(negedge clk);
    sel_wr = 1'b0;
    if (fault_o) begin
      flt = 1'b1;
      code = fault_code;
      chk(!mem_req && !busy && !done_o, "R10", "fault with activity", {31'd0, mem_req}, 32'd0);
      return;
    end
    waitc = 0;
    guard = 0;
    while (!done_o && guard < 50) begin
      guard++;
      chk(busy == 1'b1, "R8", "busy during lookup", {31'd0, busy}, 32'd1);
      if (inject && guard == 1) begin
        sel_wr = 1'b1; sel_val = 16'h0028; sel_tgt = 2'd3; sel_ldtr = 1'b0;
      end
      if (mem_req) begin
        if (waitc >= (nrd + int'(s[5:3])) % 3) begin
          mem_ack = 1'b1;
          mem_rdata = memw(mem_addr);
          if (nrd == 0) a0 = mem_addr; else a1 = mem_addr;
          nrd++;
          waitc = 0;
        end else begin
          waitc++;
        end
      end
      @(negedge clk);
      mem_ack = 1'b0;
      sel_wr = 1'b0;
    end
    chk(done_o == 1'b1, "R8", "done pulse", {31'd0, done_o}, 32'd1);
    chk(busy == 1'b0, "R8", "busy after done", {31'd0, busy}, 32'd0);
  endtask

  // one lookup with its expected outcome; base_exp is the table base the address uses
  task automatic expect_lookup(input logic [15:0] s, input logic to_ldtr, input logic [1:0] tgt,
                               input logic [1:0] exp_code, input logic [31:0] base_exp,
                               input logic inject, input string req);
    logic        flt;
    logic [1:0]  code;
    logic [31:0] a0, a1, lo, hi, ea0;
    int          nrd;
    run_lookup(s, to_ldtr, tgt, inject, flt, code, a0, a1, nrd);
    if (exp_code != 2'd0) begin
      chk(flt, req, "fault expected", {31'd0, flt}, 32'd1);
      chk(code == exp_code, req, "fault code", {30'd0, code}, {30'd0, exp_code});
      chk(nrd == 0, req, "reads on fault", nrd, 32'd0);
    end else begin
      ea0 = base_exp + ({16'd0, s} >> 3) * 32'd8;
      chk(!flt, req, "unexpected fault", {30'd0, code}, 32'd0);
      chk(nrd == 2, "R4", "read count", nrd, 32'd2);
      chk(a0 == ea0, "R1", "first address", a0, ea0);
      chk(a1 == ea0 + 32'd4, "R4", "second address", a1, ea0 + 32'd4);
      lo = memw(ea0);
      hi = memw(ea0 + 32'd4);
      if (to_ldtr) begin
        e_ldt_b = {hi[31:24], hi[7:0], lo[31:16]};
        e_ldt_l = {hi[19:16], lo[15:0]};
      end else begin
        ev[tgt] = 1'b1;
        eb[tgt] = {hi[31:24], hi[7:0], lo[31:16]};
        el[tgt] = {hi[19:16], lo[15:0]};
        ea[tgt] = hi[15:8];
        ef[tgt] = hi[23:20];
      end
    end
    check_shadow(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      ev[i] = 1'b0; eb[i] = '0; el[i] = '0; ea[i] = '0; ef[i] = '0;
    end
    e_ldt_b = '0;
    e_ldt_l = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk(!busy && !mem_req && !done_o && !fault_o, "R9", "idle outputs",
        {28'd0, busy, mem_req, done_o, fault_o}, 32'd0);
    chk(fault_code == 2'd0, "R9", "fault code", {30'd0, fault_code}, 32'd0);
    check_shadow("R9");

    // R3: null global selector, before any table load
    expect_lookup(16'h0003, 1'b0, 2'd0, 2'd1, 32'd0, 1'b0, "R3");

    // R6: table register words, index 3 write ignored
    gdtr_put(2'd0, 16'h003F);
    gdtr_put(2'd1, 16'h1000);
    gdtr_put(2'd2, 16'h0001);
    gdtr_put(2'd3, 16'hFFFF);

    // R1 R2 R3 R5 R6: sweep global indexes, RPL and target varying
    for (int k = 0; k < 10; k++) begin
      logic [15:0] s;
      logic [1:0]  c;
      s = {k[12:0], 1'b0, k[1:0]};
      if (k == 0)      c = 2'd1;
      else if (k >= 8) c = 2'd2;
      else             c = 2'd0;
      expect_lookup(s, 1'b0, k[1:0], c, GBASE, 1'b0, (k >= 8) ? "R2" : "R5");
    end

    // R7: local table load naming the local table faults
    expect_lookup(16'h001C, 1'b1, 2'd0, 2'd3, GBASE, 1'b0, "R7");
    // R7: load local table register from global index 3
    expect_lookup(16'h0019, 1'b1, 2'd0, 2'd0, GBASE, 1'b0, "R7");
    chk(ldt_base_o == LBASE, "R7", "ldt base value", ldt_base_o, LBASE);
    chk(ldt_lim_o == 20'h27, "R7", "ldt limit value", {12'd0, ldt_lim_o}, 32'h27);

    // R1 R3 R2: local sweep, index 0 fetched, index 5+ past limit 0x27
    for (int k = 0; k < 7; k++) begin
      logic [15:0] s;
      s = {k[12:0], 1'b1, ~k[1:0]};
      expect_lookup(s, 1'b0, k[1:0], (k >= 5) ? 2'd2 : 2'd0, LBASE, 1'b0,
                    (k == 0) ? "R3" : ((k >= 5) ? "R2" : "R1"));
    end

    // R8: write during busy is ignored, target 3 keeps its contents
    expect_lookup(16'h0010, 1'b0, 2'd0, 2'd0, GBASE, 1'b1, "R8");
    repeat (2) @(negedge clk);
    chk(!mem_req && !busy && !fault_o, "R8", "no follow-up activity",
        {29'd0, mem_req, busy, fault_o}, 32'd0);
    check_shadow("R8");

    // R2 boundary: limit 0x3E rejects index 7, 0x3F accepts it
    gdtr_put(2'd0, 16'h003E);
    expect_lookup(16'h0038, 1'b0, 2'd1, 2'd2, GBASE, 1'b0, "R2");
    gdtr_put(2'd0, 16'h003F);
    expect_lookup(16'h0038, 1'b0, 2'd1, 2'd0, GBASE, 1'b0, "R2");
    expect_lookup(16'h0000, 1'b1, 2'd0, 2'd1, GBASE, 1'b0, "R3");

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule